// File: doc/BRIEF.md
# Interrupt Entry/Exit Stack Sequencer

This block moves a small CPU's context to and from the stack when it takes an interrupt, takes a divide-by-zero trap, or returns from either. A configuration bit chooses the frame format. In legacy format, entry saves the program counter and the flags. While that handler runs, the interrupt segment stands in for the code segment on every fetch. In extended format, entry also saves the code segment register and then reloads it from the interrupt segment. The matching return restores that register from the stack. The block owns the code segment register and the frame-format bit. It drives a byte-wide stack port that writes on the clock edge and reads combinationally. It also drives a byte-wide vector-read port with its segment, and it reports the new program counter and the restored flags to the core.

The divide-by-zero trap saves only the program counter. Its vector sits at offsets 0002h/0003h of the segment currently used for fetches, and it is undone by a plain subroutine return. A peripheral interrupt's vector offset is built from a programmed table base in the upper bits and a hardware channel number in the lower bits. A top-level interrupt uses offsets 0004h/0005h. The frame format is latched at entry and kept per nesting level, so each return uses the frame format that its own entry used.

The sequencer has the states IDLE, PUSH_PCL, PUSH_PCH, PUSH_FLG, PUSH_CSR, VEC_LO, VEC_HI, POP_CSR, POP_FLG, POP_PCH and POP_PCL.
- From IDLE, a trap or an interrupt goes to PUSH_PCL. A return-from-interrupt goes to POP_CSR in extended format, or to POP_FLG in legacy format. A subroutine return goes to POP_PCH.
- PUSH_PCL always goes to PUSH_PCH.
- PUSH_PCH goes to VEC_LO for a trap and to PUSH_FLG for an interrupt.
- PUSH_FLG goes to PUSH_CSR in extended format and to VEC_LO in legacy format.
- PUSH_CSR goes to VEC_LO, VEC_LO goes to VEC_HI, and VEC_HI returns to IDLE.
- The pops run POP_CSR → POP_FLG → POP_PCH → POP_PCL → IDLE.

Top module: `irq_frame_seq`

## Requirements
- R1: Reset is synchronous and active high. After reset, busy is 0, the frame-format bit is 0 (legacy), the code segment register is 00h, fetch_seg is 00h, and the first push writes the top-of-stack address TOS (default 00FFh).
- R2: A legacy-format interrupt writes PC[7:0] at SP, PC[15:8] at SP-1 and the flags at SP-2 on consecutive cycles. It then reads the vector low byte and high byte in two cycles, and loads PC = {high, low}. Busy is high for exactly 5 cycles.
- R3: Inside a legacy-format handler, fetch_seg equals the interrupt segment value, and writes to the code segment register leave fetch_seg unchanged.
- R4: An extended-format interrupt also writes the old code segment register at SP-3, giving 6 busy cycles. Afterwards the code segment register and fetch_seg hold the interrupt segment value.
- R5: An extended-format return-from-interrupt pops the code segment register, then the flags, then PC[15:8], then PC[7:0], at ascending addresses over 4 busy cycles. It restores the code segment register, pulses flags_load with the flags byte, and loads the PC.
- R6: A legacy-format return-from-interrupt pops the flags, PC[15:8] and PC[7:0] over 3 busy cycles. It leaves the code segment register unchanged, so fetch_seg afterwards equals the code segment register.
- R7: The divide-by-zero trap pushes only PC[7:0] and PC[15:8]. It reads its vector at offsets 0002h/0003h of the current fetch_seg, takes 4 busy cycles, and changes neither fetch_seg nor the code segment register.
- R8: A subroutine return pops PC[15:8] and then PC[7:0] over 2 busy cycles, with no flags_load.
- R9: With irq_top = 1 the vector is read at offsets 0004h and 0005h of the interrupt segment. With irq_top = 0 it is read at {vec_base, irq_chan, 0} and at that value plus 1.
- R10: Requests that arrive while busy is high are ignored and are not queued.
- R11: The frame-format bit is sampled when an entry starts. A return uses the format of its matching entry, even if the bit changed in between.
- R12: When requests arrive in IDLE in the same cycle, the priority is: trap, then interrupt, then return-from-interrupt, then subroutine return.
- R13: Nested interrupts up to NEST_MAX deep each keep their own frame format, and fetch_seg follows the innermost active handler.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_wr_en | input | 1 | Write strobe for the frame-format bit |
| mode_wr_val | input | 1 | New frame-format bit (0 legacy, 1 extended) |
| csr_wr_en | input | 1 | Program write strobe for the code segment register |
| csr_wr_val | input | 8 | New code segment value |
| isr_seg | input | 8 | Interrupt segment register value |
| irq_req | input | 1 | Interrupt entry request |
| irq_top | input | 1 | 1 selects the top-level vector |
| irq_chan | input | CH_W | Hardware channel number for the vector offset |
| vec_base | input | 15-CH_W | Programmed vector table base bits |
| div0_req | input | 1 | Divide-by-zero trap request |
| iret_req | input | 1 | Return-from-interrupt request |
| ret_req | input | 1 | Subroutine return request |
| pc_in | input | 16 | Program counter to save |
| flags_in | input | 8 | Flags to save |
| busy | output | 1 | Sequence in progress |
| stk_we | output | 1 | Stack byte write |
| stk_re | output | 1 | Stack byte read |
| stk_addr | output | SP_W | Stack byte address |
| stk_wdata | output | 8 | Stack write data |
| stk_rdata | input | 8 | Stack read data, valid in the same cycle as stk_re |
| vec_rd | output | 1 | Vector byte read |
| vec_seg | output | 8 | Segment of the vector read |
| vec_addr | output | 16 | Offset of the vector read |
| vec_rdata | input | 8 | Vector read data, valid in the same cycle as vec_rd |
| pc_load | output | 1 | Load pc_out into the program counter |
| pc_out | output | 16 | New program counter |
| flags_load | output | 1 | Load flags_out into the flags |
| flags_out | output | 8 | Restored flags |
| fetch_seg | output | 8 | Segment used for instruction fetch |

## Verification
The assertions check on every cycle the properties that follow from one transition:
- the stack pointer moves by one in the direction of each access, and never moves both ways at once;
- the port stays quiet in IDLE;
- a trap frame goes straight from the PC high byte to the vector read;
- a return pops PC high just before PC low;
- the code segment register takes a value it is handed;
- the nesting depth steps on each entry.

Only the bench scenarios can show the whole frame. That covers byte order and addresses, the vector offsets for each table setting, and the PC rebuilt from both vector bytes. It also covers a return that keeps its entry's frame format after the bit flips, ignored requests during busy, and fetch_seg as handlers nest and unwind.

// File: rtl/irq_frame_pkg.sv
package irq_frame_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_PUSH_PCL,
        S_PUSH_PCH,
        S_PUSH_FLG,
        S_PUSH_CSR,
        S_VEC_LO,
        S_VEC_HI,
        S_POP_CSR,
        S_POP_FLG,
        S_POP_PCH,
        S_POP_PCL
    } seq_state_t;

    typedef enum logic [1:0] {
        K_INT,
        K_TRAP,
        K_IRET,
        K_RET
    } op_kind_t;

    localparam logic [15:0] TOP_VEC_OFS  = 16'h0004;
    localparam logic [15:0] DIV0_VEC_OFS = 16'h0002;

endpackage

// File: rtl/irq_frame_sp.sv
module irq_frame_sp #(
    parameter int             SP_W = 16,
    parameter logic [SP_W-1:0] TOS = 16'h00FF
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            push,
    input  logic            pop,
    output logic [SP_W-1:0] stk_addr
);
    localparam logic [SP_W-1:0] SP_ONE = SP_W'(1);

    logic [SP_W-1:0] sp;

    always_ff @(posedge clk) begin
        if (rst)       sp <= TOS;
        else if (push) sp <= sp - SP_ONE;
        else if (pop)  sp <= sp + SP_ONE;
    end

    // Post-decrement push, pre-increment pop.
    assign stk_addr = pop ? (sp + SP_ONE) : sp;

    assert_one_dir_R2: assert property (@(posedge clk) disable iff (rst)
        $onehot0({push, pop}));

    assert_push_step_R2: assert property (@(posedge clk) disable iff (rst)
        push |=> sp == $past(sp) - SP_ONE);

    assert_pop_step_R5: assert property (@(posedge clk) disable iff (rst)
        pop |=> sp == $past(sp) + SP_ONE);

endmodule

// File: rtl/irq_frame_ctx.sv
module irq_frame_ctx #(
    parameter int NEST_MAX = 4
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       mode_wr_en,
    input  logic       mode_wr_val,
    input  logic       csr_wr_en,
    input  logic [7:0] csr_wr_val,
    input  logic       csr_ld,
    input  logic [7:0] csr_ld_val,
    input  logic       enter_int,
    input  logic       enter_mode,
    input  logic       leave_int,
    input  logic [7:0] isr_seg,
    output logic       mode_cur,
    output logic       mode_top,
    output logic [7:0] csr_q,
    output logic [7:0] fetch_seg
);
    localparam int             DW   = $clog2(NEST_MAX + 1);
    localparam logic [DW-1:0]  DMAX = DW'(NEST_MAX);
    localparam logic [DW-1:0]  DONE = DW'(1);

    logic [DW-1:0]       depth;
    logic [NEST_MAX-1:0] hist;

    always_ff @(posedge clk) begin
        if (rst) begin
            mode_cur <= 1'b0;
            csr_q    <= 8'h00;
            depth    <= '0;
            hist     <= '0;
        end else begin
            if (mode_wr_en) mode_cur <= mode_wr_val;
            if (csr_ld)          csr_q <= csr_ld_val;
            else if (csr_wr_en)  csr_q <= csr_wr_val;
            if (enter_int) begin
                hist <= {hist[NEST_MAX-2:0], enter_mode};
                if (depth != DMAX) depth <= depth + DONE;
            end else if (leave_int) begin
                hist <= {1'b0, hist[NEST_MAX-1:1]};
                if (depth != '0) depth <= depth - DONE;
            end
        end
    end

    assign mode_top  = hist[0];
    assign fetch_seg = (depth != '0 && !hist[0]) ? isr_seg : csr_q;

    assert_csr_load_R4: assert property (@(posedge clk) disable iff (rst)
        csr_ld |=> csr_q == $past(csr_ld_val));

    assert_depth_step_R13: assert property (@(posedge clk) disable iff (rst)
        (enter_int && depth != DMAX) |=> depth == $past(depth) + DONE);

endmodule

// File: rtl/irq_frame_ctl.sv
module irq_frame_ctl
    import irq_frame_pkg::*;
#(
    parameter int CH_W = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            irq_req,
    input  logic            irq_top,
    input  logic [CH_W-1:0] irq_chan,
    input  logic [14-CH_W:0] vec_base,
    input  logic            div0_req,
    input  logic            iret_req,
    input  logic            ret_req,
    input  logic [15:0]     pc_in,
    input  logic [7:0]      flags_in,
    input  logic            mode_cur,
    input  logic            mode_top,
    input  logic [7:0]      isr_seg,
    input  logic [7:0]      fetch_seg,
    input  logic [7:0]      csr_q,
    input  logic [7:0]      stk_rdata,
    input  logic [7:0]      vec_rdata,
    output logic            busy,
    output logic            push,
    output logic            pop,
    output logic [7:0]      stk_wdata,
    output logic            vec_rd,
    output logic [7:0]      vec_seg,
    output logic [15:0]     vec_addr,
    output logic            pc_load,
    output logic [15:0]     pc_out,
    output logic            flags_load,
    output logic [7:0]      flags_out,
    output logic            enter_int,
    output logic            enter_mode,
    output logic            leave_int,
    output logic            csr_ld,
    output logic [7:0]      csr_ld_val
);
    seq_state_t state, nxt;
    op_kind_t   kind;
    logic       fmode;
    logic [15:0] pc_sv, vaddr;
    logic [7:0]  flg_sv, csr_sv, vseg, vlo, pch;

    // State register
    always_ff @(posedge clk) begin
        if (rst) state <= S_IDLE;
        else     state <= nxt;
    end

    // Transitions
    always_comb begin
        nxt = state;
        unique case (state)
            S_IDLE: begin
                if (div0_req || irq_req) nxt = S_PUSH_PCL;
                else if (iret_req)       nxt = mode_top ? S_POP_CSR : S_POP_FLG;
                else if (ret_req)        nxt = S_POP_PCH;
            end
            S_PUSH_PCL: nxt = S_PUSH_PCH;
            S_PUSH_PCH: nxt = (kind == K_TRAP) ? S_VEC_LO : S_PUSH_FLG;
            S_PUSH_FLG: nxt = fmode ? S_PUSH_CSR : S_VEC_LO;
            S_PUSH_CSR: nxt = S_VEC_LO;
            S_VEC_LO:   nxt = S_VEC_HI;
            S_VEC_HI:   nxt = S_IDLE;
            S_POP_CSR:  nxt = S_POP_FLG;
            S_POP_FLG:  nxt = S_POP_PCH;
            S_POP_PCH:  nxt = S_POP_PCL;
            S_POP_PCL:  nxt = S_IDLE;
            default:    nxt = S_IDLE;
        endcase
    end

    // Context captured at the start of a sequence and during it
    always_ff @(posedge clk) begin
        if (rst) begin
            kind   <= K_INT;
            fmode  <= 1'b0;
            pc_sv  <= '0;
            flg_sv <= '0;
            csr_sv <= '0;
            vseg   <= '0;
            vaddr  <= '0;
            vlo    <= '0;
            pch    <= '0;
        end else begin
            if (state == S_IDLE) begin
                pc_sv  <= pc_in;
                flg_sv <= flags_in;
                csr_sv <= csr_q;
                if (div0_req) begin
                    kind  <= K_TRAP;
                    fmode <= 1'b0;
                    vseg  <= fetch_seg;
                    vaddr <= DIV0_VEC_OFS;
                end else begin
                    vseg  <= isr_seg;
                    vaddr <= irq_top ? TOP_VEC_OFS : {vec_base, irq_chan, 1'b0};
                    if (irq_req) begin
                        kind  <= K_INT;
                        fmode <= mode_cur;
                    end else if (iret_req) begin
                        kind  <= K_IRET;
                        fmode <= mode_top;
                    end else begin
                        kind  <= K_RET;
                        fmode <= 1'b0;
                    end
                end
            end
            if (state == S_VEC_LO)  vlo <= vec_rdata;
            if (state == S_POP_PCH) pch <= stk_rdata;
        end
    end

    // Outputs
    always_comb begin
        busy       = (state != S_IDLE);
        push       = 1'b0;
        pop        = 1'b0;
        stk_wdata  = 8'h00;
        vec_rd     = 1'b0;
        vec_seg    = vseg;
        vec_addr   = vaddr;
        pc_load    = 1'b0;
        pc_out     = 16'h0000;
        flags_load = 1'b0;
        flags_out  = 8'h00;
        enter_int  = 1'b0;
        enter_mode = fmode;
        leave_int  = 1'b0;
        csr_ld     = 1'b0;
        csr_ld_val = 8'h00;
        unique case (state)
            S_IDLE: ;
            S_PUSH_PCL: begin push = 1'b1; stk_wdata = pc_sv[7:0];  end
            S_PUSH_PCH: begin push = 1'b1; stk_wdata = pc_sv[15:8]; end
            S_PUSH_FLG: begin push = 1'b1; stk_wdata = flg_sv;      end
            S_PUSH_CSR: begin push = 1'b1; stk_wdata = csr_sv;      end
            S_VEC_LO:   vec_rd = 1'b1;
            S_VEC_HI: begin
                vec_rd   = 1'b1;
                vec_addr = vaddr + 16'h0001;
                pc_load  = 1'b1;
                pc_out   = {vec_rdata, vlo};
                if (kind == K_INT) begin
                    enter_int  = 1'b1;
                    csr_ld     = fmode;
                    csr_ld_val = vseg;
                end
            end
            S_POP_CSR: begin
                pop        = 1'b1;
                csr_ld     = 1'b1;
                csr_ld_val = stk_rdata;
            end
            S_POP_FLG: begin
                pop        = 1'b1;
                flags_load = 1'b1;
                flags_out  = stk_rdata;
            end
            S_POP_PCH: pop = 1'b1;
            S_POP_PCL: begin
                pop       = 1'b1;
                pc_load   = 1'b1;
                pc_out    = {pch, stk_rdata};
                leave_int = (kind == K_IRET);
            end
            default: ;
        endcase
    end

    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (!push && !pop && !vec_rd && !pc_load));

    assert_trap_frame_R7: assert property (@(posedge clk) disable iff (rst)
        (state == S_VEC_LO && kind == K_TRAP) |-> $past(state) == S_PUSH_PCH);

    assert_pop_order_R5: assert property (@(posedge clk) disable iff (rst)
        (state == S_POP_PCL) |-> $past(state) == S_POP_PCH);

    assert_start_from_idle_R10: assert property (@(posedge clk) disable iff (rst)
        (state == S_PUSH_PCL) |-> $past(state) == S_IDLE);

endmodule

// File: rtl/irq_frame_seq.sv
module irq_frame_seq #(
    parameter int              CH_W     = 3,
    parameter int              NEST_MAX = 4,
    parameter int              SP_W     = 16,
    parameter logic [SP_W-1:0] TOS      = 16'h00FF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             mode_wr_en,
    input  logic             mode_wr_val,
    input  logic             csr_wr_en,
    input  logic [7:0]       csr_wr_val,
    input  logic [7:0]       isr_seg,
    input  logic             irq_req,
    input  logic             irq_top,
    input  logic [CH_W-1:0]  irq_chan,
    input  logic [14-CH_W:0] vec_base,
    input  logic             div0_req,
    input  logic             iret_req,
    input  logic             ret_req,
    input  logic [15:0]      pc_in,
    input  logic [7:0]       flags_in,
    output logic             busy,
    output logic             stk_we,
    output logic             stk_re,
    output logic [SP_W-1:0]  stk_addr,
    output logic [7:0]       stk_wdata,
    input  logic [7:0]       stk_rdata,
    output logic             vec_rd,
    output logic [7:0]       vec_seg,
    output logic [15:0]      vec_addr,
    input  logic [7:0]       vec_rdata,
    output logic             pc_load,
    output logic [15:0]      pc_out,
    output logic             flags_load,
    output logic [7:0]       flags_out,
    output logic [7:0]       fetch_seg
);
    logic       mode_cur, mode_top;
    logic [7:0] csr_q;
    logic       enter_int, enter_mode, leave_int, csr_ld;
    logic [7:0] csr_ld_val;

    irq_frame_ctl #(.CH_W(CH_W)) ctl_i (
        .clk        (clk),
        .rst        (rst),
        .irq_req    (irq_req),
        .irq_top    (irq_top),
        .irq_chan   (irq_chan),
        .vec_base   (vec_base),
        .div0_req   (div0_req),
        .iret_req   (iret_req),
        .ret_req    (ret_req),
        .pc_in      (pc_in),
        .flags_in   (flags_in),
        .mode_cur   (mode_cur),
        .mode_top   (mode_top),
        .isr_seg    (isr_seg),
        .fetch_seg  (fetch_seg),
        .csr_q      (csr_q),
        .stk_rdata  (stk_rdata),
        .vec_rdata  (vec_rdata),
        .busy       (busy),
        .push       (stk_we),
        .pop        (stk_re),
        .stk_wdata  (stk_wdata),
        .vec_rd     (vec_rd),
        .vec_seg    (vec_seg),
        .vec_addr   (vec_addr),
        .pc_load    (pc_load),
        .pc_out     (pc_out),
        .flags_load (flags_load),
        .flags_out  (flags_out),
        .enter_int  (enter_int),
        .enter_mode (enter_mode),
        .leave_int  (leave_int),
        .csr_ld     (csr_ld),
        .csr_ld_val (csr_ld_val)
    );

    irq_frame_sp #(.SP_W(SP_W), .TOS(TOS)) sp_i (
        .clk      (clk),
        .rst      (rst),
        .push     (stk_we),
        .pop      (stk_re),
        .stk_addr (stk_addr)
    );

    irq_frame_ctx #(.NEST_MAX(NEST_MAX)) ctx_i (
        .clk         (clk),
        .rst         (rst),
        .mode_wr_en  (mode_wr_en),
        .mode_wr_val (mode_wr_val),
        .csr_wr_en   (csr_wr_en),
        .csr_wr_val  (csr_wr_val),
        .csr_ld      (csr_ld),
        .csr_ld_val  (csr_ld_val),
        .enter_int   (enter_int),
        .enter_mode  (enter_mode),
        .leave_int   (leave_int),
        .isr_seg     (isr_seg),
        .mode_cur    (mode_cur),
        .mode_top    (mode_top),
        .csr_q       (csr_q),
        .fetch_seg   (fetch_seg)
    );

endmodule

// File: tb/irq_frame_seq_tb.sv
module irq_frame_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_wr_en = 1'b0, mode_wr_val = 1'b0;
    logic        csr_wr_en = 1'b0;
    logic [7:0]  csr_wr_val = 8'h00;
    logic [7:0]  isr_seg = 8'h00;
    logic        irq_req = 1'b0, irq_top = 1'b0;
    logic [2:0]  irq_chan = 3'd0;
    logic [11:0] vec_base = 12'h000;
    logic        div0_req = 1'b0, iret_req = 1'b0, ret_req = 1'b0;
    logic [15:0] pc_in = 16'h0000;
    logic [7:0]  flags_in = 8'h00;
    logic        busy, stk_we, stk_re, vec_rd, pc_load, flags_load;
    logic [15:0] stk_addr, vec_addr, pc_out;
    logic [7:0]  stk_wdata, stk_rdata, vec_seg, vec_rdata, flags_out, fetch_seg;

    logic [7:0] smem [256];

    function automatic logic [7:0] vdat(input logic [7:0] s, input logic [15:0] a);
        return a[7:0] ^ a[15:8] ^ {s[3:0], s[7:4]} ^ 8'hA5;
    endfunction

    assign stk_rdata = smem[stk_addr[7:0]];
    assign vec_rdata = vdat(vec_seg, vec_addr);

    always #4 clk = ~clk;

    irq_frame_seq dut_i (
        .clk(clk), .rst(rst),
        .mode_wr_en(mode_wr_en), .mode_wr_val(mode_wr_val),
        .csr_wr_en(csr_wr_en), .csr_wr_val(csr_wr_val),
        .isr_seg(isr_seg), .irq_req(irq_req), .irq_top(irq_top),
        .irq_chan(irq_chan), .vec_base(vec_base), .div0_req(div0_req),
        .iret_req(iret_req), .ret_req(ret_req), .pc_in(pc_in),
        .flags_in(flags_in), .busy(busy), .stk_we(stk_we), .stk_re(stk_re),
        .stk_addr(stk_addr), .stk_wdata(stk_wdata), .stk_rdata(stk_rdata),
        .vec_rd(vec_rd), .vec_seg(vec_seg), .vec_addr(vec_addr),
        .vec_rdata(vec_rdata), .pc_load(pc_load), .pc_out(pc_out),
        .flags_load(flags_load), .flags_out(flags_out), .fetch_seg(fetch_seg)
    );

    int checks = 0, failures = 0;
    int wr_n, rd_n, vn, pcn, fln, busy_n;
    logic [15:0] wa [8];
    logic [7:0]  wd [8];
    logic [15:0] ra [8];
    logic [15:0] va [4];
    logic [7:0]  vs, flv;
    logic [15:0] pcv;

    // Monitor: samples mid-cycle, also models the stack memory write
    always @(negedge clk) begin
        if (!rst) begin
            if (busy) busy_n++;
            if (stk_we) begin
                smem[stk_addr[7:0]] = stk_wdata;
                if (wr_n < 8) begin wa[wr_n] = stk_addr; wd[wr_n] = stk_wdata; end
                wr_n++;
            end
            if (stk_re) begin
                if (rd_n < 8) ra[rd_n] = stk_addr;
                rd_n++;
            end
            if (vec_rd) begin
                if (vn < 4) va[vn] = vec_addr;
                vs = vec_seg;
                vn++;
            end
            if (pc_load)    begin pcv = pc_out; pcn++; end
            if (flags_load) begin flv = flags_out; fln++; end
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clr_log();
        wr_n = 0; rd_n = 0; vn = 0; pcn = 0; fln = 0; busy_n = 0;
    endtask

    task automatic op(input logic d0, input logic ir, input logic it, input logic rt);
        clr_log();
        @(posedge clk); #1;
        div0_req = d0; irq_req = ir; iret_req = it; ret_req = rt;
        @(posedge clk); #1;
        div0_req = 1'b0; irq_req = 1'b0; iret_req = 1'b0; ret_req = 1'b0;
        while (busy) begin @(posedge clk); #1; end
    endtask

    task automatic set_mode(input logic m);
        @(posedge clk); #1; mode_wr_en = 1'b1; mode_wr_val = m;
        @(posedge clk); #1; mode_wr_en = 1'b0;
    endtask

    task automatic set_csr(input logic [7:0] v);
        @(posedge clk); #1; csr_wr_en = 1'b1; csr_wr_val = v;
        @(posedge clk); #1; csr_wr_en = 1'b0;
    endtask

    // {top, chan, base, isr_seg, expected vector offset}
    localparam logic [39:0] VTAB [5] = '{
        {1'b1, 3'd5, 12'h123, 8'h21, 16'h0004},
        {1'b0, 3'd0, 12'h000, 8'h30, 16'h0000},
        {1'b0, 3'd5, 12'h010, 8'h30, 16'h010A},
        {1'b0, 3'd7, 12'hFFF, 8'h7E, 16'hFFFE},
        {1'b0, 3'd2, 12'h0AB, 8'h01, 16'h0AB4}
    };

    initial begin
        repeat (50000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        for (int i = 0; i < 256; i++) smem[i] = 8'h00;
        clr_log();
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(posedge clk); #1;
        chk("R1 busy after reset", busy, 0);
        chk("R1 fetch_seg after reset", fetch_seg, 8'h00);

        // R9: vector offset table, legacy format, unwound each time
        for (int i = 0; i < 5; i++) begin
            logic [39:0] e;
            logic [15:0] xa;
            e = VTAB[i];
            xa = e[15:0];
            irq_top = e[39]; irq_chan = e[38:36]; vec_base = e[35:24]; isr_seg = e[23:16];
            pc_in = 16'h1000 + 16'(i); flags_in = 8'(i);
            op(1'b0, 1'b1, 1'b0, 1'b0);
            chk("R9 vector low offset", va[0], xa);
            chk("R9 vector high offset", va[1], xa + 16'h1);
            chk("R9 vector segment", vs, e[23:16]);
            chk("R9 pc from vector", pcv, {vdat(e[23:16], xa + 16'h1), vdat(e[23:16], xa)});
            chk("R1 first push at TOS", wa[0], 16'h00FF);
            op(1'b0, 1'b0, 1'b1, 1'b0);
        end

        // R2/R3/R6/R11: legacy entry, then flip format before return
        set_csr(8'h40);
        irq_top = 1'b1; isr_seg = 8'h11; pc_in = 16'hBEEF; flags_in = 8'h3C;
        op(1'b0, 1'b1, 1'b0, 1'b0);
        chk("R2 push count", wr_n, 3);
        chk("R2 push addr0", wa[0], 16'h00FF);
        chk("R2 push addr2", wa[2], 16'h00FD);
        chk("R2 pc low byte", wd[0], 8'hEF);
        chk("R2 pc high byte", wd[1], 8'hBE);
        chk("R2 flags byte", wd[2], 8'h3C);
        chk("R2 busy cycles", busy_n, 5);
        chk("R2 pc loaded", pcv, {vdat(8'h11, 16'h0005), vdat(8'h11, 16'h0004)});
        chk("R3 fetch_seg in legacy handler", fetch_seg, 8'h11);
        set_csr(8'h99);
        chk("R3 csr write ignored for fetch", fetch_seg, 8'h11);
        set_mode(1'b1);
        op(1'b0, 1'b0, 1'b1, 1'b0);
        chk("R6 pop count", rd_n, 3);
        chk("R11 legacy frame kept busy", busy_n, 3);
        chk("R6 pop addr0", ra[0], 16'h00FD);
        chk("R6 pop addr2", ra[2], 16'h00FF);
        chk("R6 flags restored", flv, 8'h3C);
        chk("R6 pc restored", pcv, 16'hBEEF);
        chk("R6 fetch_seg back to csr", fetch_seg, 8'h99);

        // R4/R5/R11: extended entry, flip to legacy before return
        isr_seg = 8'h22; pc_in = 16'h1234; flags_in = 8'h81;
        op(1'b0, 1'b1, 1'b0, 1'b0);
        chk("R4 push count", wr_n, 4);
        chk("R4 csr pushed addr", wa[3], 16'h00FC);
        chk("R4 csr pushed data", wd[3], 8'h99);
        chk("R4 busy cycles", busy_n, 6);
        chk("R4 fetch_seg after entry", fetch_seg, 8'h22);
        set_mode(1'b0);
        op(1'b0, 1'b0, 1'b1, 1'b0);
        chk("R5 pop count", rd_n, 4);
        chk("R11 extended frame kept busy", busy_n, 4);
        chk("R5 pop addr0", ra[0], 16'h00FC);
        chk("R5 pop addr3", ra[3], 16'h00FF);
        chk("R5 csr restored", fetch_seg, 8'h99);
        chk("R5 flags restored", flv, 8'h81);
        chk("R5 flags_load count", fln, 1);
        chk("R5 pc restored", pcv, 16'h1234);

        // R7/R8: divide-by-zero trap and subroutine return
        pc_in = 16'h5678; flags_in = 8'hFF;
        op(1'b1, 1'b0, 1'b0, 1'b0);
        chk("R7 push count", wr_n, 2);
        chk("R7 pushed pc low", wd[0], 8'h78);
        chk("R7 pushed pc high", wd[1], 8'h56);
        chk("R7 vector offset", va[0], 16'h0002);
        chk("R7 vector segment", vs, 8'h99);
        chk("R7 busy cycles", busy_n, 4);
        chk("R7 pc loaded", pcv, {vdat(8'h99, 16'h0003), vdat(8'h99, 16'h0002)});
        chk("R7 fetch_seg unchanged", fetch_seg, 8'h99);
        op(1'b0, 1'b0, 1'b0, 1'b1);
        chk("R8 pop count", rd_n, 2);
        chk("R8 busy cycles", busy_n, 2);
        chk("R8 no flags load", fln, 0);
        chk("R8 pc restored", pcv, 16'h5678);

        // R10: requests during busy are dropped
        clr_log();
        isr_seg = 8'h44; pc_in = 16'hAAAA;
        @(posedge clk); #1 irq_req = 1'b1;
        @(posedge clk); #1 irq_req = 1'b0;
        @(posedge clk); #1 irq_req = 1'b1; div0_req = 1'b1; iret_req = 1'b1; ret_req = 1'b1;
        @(posedge clk); #1 irq_req = 1'b0; div0_req = 1'b0; iret_req = 1'b0; ret_req = 1'b0;
        while (busy) begin @(posedge clk); #1; end
        repeat (3) @(posedge clk);
        #1;
        chk("R10 push count", wr_n, 3);
        chk("R10 busy cycles", busy_n, 5);
        chk("R10 no pops", rd_n, 0);
        chk("R10 idle afterwards", busy, 0);
        op(1'b0, 1'b0, 1'b1, 1'b0);

        // R12: priority among simultaneous requests
        op(1'b1, 1'b1, 1'b0, 1'b0);
        chk("R12 trap wins over irq", va[0], 16'h0002);
        chk("R12 trap frame size", wr_n, 2);
        op(1'b0, 1'b0, 1'b0, 1'b1);
        op(1'b0, 1'b1, 1'b1, 1'b0);
        chk("R12 irq wins over iret", wr_n, 3);
        op(1'b0, 1'b0, 1'b1, 1'b1);
        chk("R12 iret wins over ret", rd_n, 3);
        chk("R12 iret restores flags", fln, 1);

        // R13: nested handlers with different formats
        set_mode(1'b1);
        isr_seg = 8'h22;
        op(1'b0, 1'b1, 1'b0, 1'b0);
        set_mode(1'b0);
        isr_seg = 8'h33;
        op(1'b0, 1'b1, 1'b0, 1'b0);
        chk("R13 inner legacy fetch_seg", fetch_seg, 8'h33);
        op(1'b0, 1'b0, 1'b1, 1'b0);
        chk("R13 inner frame size", rd_n, 3);
        chk("R13 outer fetch_seg", fetch_seg, 8'h22);
        op(1'b0, 1'b0, 1'b1, 1'b0);
        chk("R13 outer frame size", rd_n, 4);
        chk("R13 csr restored", fetch_seg, 8'h99);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule